// File: doc/BRIEF.md
# Dual-Host Register Access Arbiter

This block lets two independent serial hosts share one small bank of configuration registers. One host is an SPI slave engine. The other is a second, sensor-style serial engine, called the auxiliary port here. Each engine presents a request, a write enable, an address and write data. In the next cycle it gets back either a one-cycle grant or a one-cycle abort, together with registered read data.

When both engines request in the same cycle, a priority bit held in the register bank itself picks the winner. Only the winner's read or write takes place. The loser's write is dropped and its read data is forced to zero. Each port has its own sticky collision flag, and a collision sets the flag of the port that lost. Both flags sit in a status register that either host can read. A granted read of that register returns the flags and then clears them.

Internally an outcome state machine records what happened on each cycle. Its states are OUT_IDLE (no request), OUT_SPI (lone SPI request), OUT_AUX (lone auxiliary request), OUT_SPI_OVER_AUX (collision won by SPI) and OUT_AUX_OVER_SPI (collision won by the auxiliary port). Every cycle the machine moves to the state that the sampled requests and the priority bit select. The grant and abort pulses are decoded from the current state.

Top module: `dual_host_arb`

## Requirements
- R1: After reset every storage register reads 0x00, both collision flags are clear, and no grant or abort is asserted. Read data is zero.
- R2: If only one port requests in cycle N, that port's grant is high in cycle N+1 whatever the priority bit holds.
- R3: A granted write to a storage address (0x00 to NREG-1) updates the register on the edge that ends cycle N. A granted read of that address in cycle N+1 returns the new value in cycle N+2.
- R4: When both ports request in the same cycle and bit 1 of register 0x03 is 0, the auxiliary port gets the grant and the SPI port gets the abort.
- R5: When both ports request in the same cycle and bit 1 of register 0x03 is 1, the SPI port gets the grant and the auxiliary port gets the abort.
- R6: A port that loses a collision leaves the registers unchanged, and its read data is 0x00 in the abort cycle.
- R7: A collision sets the loser's flag only. In the status register at 0x4A, bit 0 is the SPI flag and bit 1 is the auxiliary flag. Bits 7:2 read as zero.
- R8: A collision flag stays set until a granted read of 0x4A. That read returns the flags as they were before the read and clears both. A loss in the same cycle as the read leaves that loser's flag set.
- R9: In each cycle after a request, a port gets either a grant or an abort, never both. Only one port is granted at a time. A port that did not request gets neither.
- R10: Reads of addresses that are neither storage nor 0x4A return 0x00, and writes to them have no effect. Writes to 0x4A do not change the flags.
- R11: A granted write returns read data 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_req | input | 1 | SPI engine access request |
| spi_we | input | 1 | SPI write enable (1 = write) |
| spi_addr | input | 8 | SPI register address |
| spi_wdata | input | 8 | SPI write data |
| spi_gnt | output | 1 | SPI access served (one-cycle pulse) |
| spi_abort | output | 1 | SPI access lost a collision (one-cycle pulse) |
| spi_rdata | output | 8 | SPI read data, valid with grant |
| aux_req | input | 1 | Auxiliary engine access request |
| aux_we | input | 1 | Auxiliary write enable |
| aux_addr | input | 8 | Auxiliary register address |
| aux_wdata | input | 8 | Auxiliary write data |
| aux_gnt | output | 1 | Auxiliary access served (one-cycle pulse) |
| aux_abort | output | 1 | Auxiliary access lost a collision (one-cycle pulse) |
| aux_rdata | output | 8 | Auxiliary read data, valid with grant |

## Verification
Requests are sampled at a clock edge. Grant, abort and read data are all registered, so for a request in cycle N every result belongs to cycle N+1. Register and flag updates land on that same edge, so their effects show up in the results of the next request. The bench drives each vector on a falling edge and waits for one rising edge. At the following falling edge it compares all six outputs against the vector's expected values, then clears the requests. Each table row therefore checks exactly one request cycle. The directed tests for reset and idle behaviour use the same one-cycle spacing.

// File: rtl/dual_host_arb_pkg.sv
package dual_host_arb_pkg;

    typedef enum logic [2:0] {
        OUT_IDLE,
        OUT_SPI,
        OUT_AUX,
        OUT_SPI_OVER_AUX,
        OUT_AUX_OVER_SPI
    } outcome_e;

endpackage

// File: rtl/dual_host_arb_fsm.sv
module dual_host_arb_fsm
    import dual_host_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic spi_req,
    input  logic aux_req,
    input  logic prio_spi,
    output logic spi_serve,
    output logic aux_serve,
    output logic spi_lose,
    output logic aux_lose,
    output logic spi_gnt,
    output logic spi_abort,
    output logic aux_gnt,
    output logic aux_abort
);

    outcome_e state_q, state_d;

    // next outcome from the sampled requests
    always_comb begin
        if (spi_req && aux_req)
            state_d = prio_spi ? OUT_SPI_OVER_AUX : OUT_AUX_OVER_SPI;
        else if (spi_req)
            state_d = OUT_SPI;
        else if (aux_req)
            state_d = OUT_AUX;
        else
            state_d = OUT_IDLE;
    end

    // same-cycle serve/lose strobes used by storage and flags
    always_comb begin
        spi_serve = 1'b0;
        aux_serve = 1'b0;
        spi_lose  = 1'b0;
        aux_lose  = 1'b0;
        unique case (state_d)
            OUT_IDLE:         ;
            OUT_SPI:          spi_serve = 1'b1;
            OUT_AUX:          aux_serve = 1'b1;
            OUT_SPI_OVER_AUX: begin spi_serve = 1'b1; aux_lose = 1'b1; end
            OUT_AUX_OVER_SPI: begin aux_serve = 1'b1; spi_lose = 1'b1; end
            default:          ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_IDLE;
        else        state_q <= state_d;
    end

    // pulses decoded from the registered outcome
    always_comb begin
        spi_gnt   = 1'b0;
        spi_abort = 1'b0;
        aux_gnt   = 1'b0;
        aux_abort = 1'b0;
        unique case (state_q)
            OUT_IDLE:         ;
            OUT_SPI:          spi_gnt = 1'b1;
            OUT_AUX:          aux_gnt = 1'b1;
            OUT_SPI_OVER_AUX: begin spi_gnt = 1'b1; aux_abort = 1'b1; end
            OUT_AUX_OVER_SPI: begin aux_gnt = 1'b1; spi_abort = 1'b1; end
            default:          ;
        endcase
    end

endmodule

// File: rtl/dual_host_arb_regs.sv
module dual_host_arb_regs #(
    parameter int DW        = 8,
    parameter int NREG      = 8,
    parameter int PRIO_ADDR = 3,
    parameter int PRIO_BIT  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] idx,
    input  logic [DW-1:0]           wr_data,
    output logic [DW-1:0]           rd_val,
    output logic                    prio_spi
);

    logic [DW-1:0] store_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                store_q[g] <= '0;
            else if (wr_en && (idx == g[$clog2(NREG)-1:0]))
                store_q[g] <= wr_data;
        end
    end

    assign rd_val   = store_q[idx];
    assign prio_spi = store_q[PRIO_ADDR][PRIO_BIT];

endmodule

// File: rtl/dual_host_arb_flags.sv
module dual_host_arb_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_lose,
    input  logic       aux_lose,
    input  logic       clr,
    output logic [1:0] flags
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= 2'b00;
        else
            flags <= (clr ? 2'b00 : flags) | {aux_lose, spi_lose};
    end

endmodule

// File: rtl/dual_host_arb.sv
module dual_host_arb #(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int NREG      = 8,
    parameter int PRIO_ADDR = 3,
    parameter int PRIO_BIT  = 1,
    parameter int STAT_ADDR = 'h4A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_req,
    input  logic          spi_we,
    input  logic [AW-1:0] spi_addr,
    input  logic [DW-1:0] spi_wdata,
    output logic          spi_gnt,
    output logic          spi_abort,
    output logic [DW-1:0] spi_rdata,
    input  logic          aux_req,
    input  logic          aux_we,
    input  logic [AW-1:0] aux_addr,
    input  logic [DW-1:0] aux_wdata,
    output logic          aux_gnt,
    output logic          aux_abort,
    output logic [DW-1:0] aux_rdata
);

    localparam int IW = $clog2(NREG);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam logic [AW-1:0] NREG_A = AW'(NREG);

    logic          spi_serve, aux_serve, spi_lose, aux_lose;
    logic          prio_spi;
    logic [1:0]    col_flags;
    logic          acc_we;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata;
    logic          acc_any, in_store, is_stat;
    logic [DW-1:0] store_val, rd_mux;

    dual_host_arb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_req   (spi_req),
        .aux_req   (aux_req),
        .prio_spi  (prio_spi),
        .spi_serve (spi_serve),
        .aux_serve (aux_serve),
        .spi_lose  (spi_lose),
        .aux_lose  (aux_lose),
        .spi_gnt   (spi_gnt),
        .spi_abort (spi_abort),
        .aux_gnt   (aux_gnt),
        .aux_abort (aux_abort)
    );

    // winner's access path
    assign acc_any   = spi_serve | aux_serve;
    assign acc_we    = spi_serve ? spi_we    : aux_we;
    assign acc_addr  = spi_serve ? spi_addr  : aux_addr;
    assign acc_wdata = spi_serve ? spi_wdata : aux_wdata;
    assign in_store  = acc_addr < NREG_A;
    assign is_stat   = acc_addr == STAT_A;

    dual_host_arb_regs #(
        .DW        (DW),
        .NREG      (NREG),
        .PRIO_ADDR (PRIO_ADDR),
        .PRIO_BIT  (PRIO_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_any && acc_we && in_store),
        .idx      (acc_addr[IW-1:0]),
        .wr_data  (acc_wdata),
        .rd_val   (store_val),
        .prio_spi (prio_spi)
    );

    dual_host_arb_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_lose (spi_lose),
        .aux_lose (aux_lose),
        .clr      (acc_any && !acc_we && is_stat),
        .flags    (col_flags)
    );

    always_comb begin
        if (is_stat)       rd_mux = DW'(col_flags);
        else if (in_store) rd_mux = store_val;
        else               rd_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_rdata <= '0;
            aux_rdata <= '0;
        end else begin
            spi_rdata <= (spi_serve && !spi_we) ? rd_mux : '0;
            aux_rdata <= (aux_serve && !aux_we) ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/dual_host_arb_chk.sv
module dual_host_arb_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          spi_req,
    input logic          aux_req,
    input logic          spi_gnt,
    input logic          spi_abort,
    input logic          aux_gnt,
    input logic          aux_abort,
    input logic [DW-1:0] spi_rdata,
    input logic [DW-1:0] aux_rdata,
    input logic          prio_spi,
    input logic [1:0]    col_flags
);

    AST_SPI_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(spi_gnt && spi_abort));                 // R9
    AST_AUX_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(aux_gnt && aux_abort));                 // R9
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) !(spi_gnt && aux_gnt));                   // R9
    AST_SPI_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !spi_req |=> !spi_gnt && !spi_abort);     // R9
    AST_AUX_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !aux_req |=> !aux_gnt && !aux_abort);     // R9
    AST_LONE_SPI:     assert property (@(posedge clk) disable iff (!rst_n) spi_req && !aux_req |=> spi_gnt);        // R2
    AST_LONE_AUX:     assert property (@(posedge clk) disable iff (!rst_n) aux_req && !spi_req |=> aux_gnt);        // R2
    AST_AUX_WINS:     assert property (@(posedge clk) disable iff (!rst_n)
                          spi_req && aux_req && !prio_spi |=> aux_gnt && spi_abort);                                // R4
    AST_SPI_WINS:     assert property (@(posedge clk) disable iff (!rst_n)
                          spi_req && aux_req && prio_spi |=> spi_gnt && aux_abort);                                 // R5
    AST_SPI_LOSS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) spi_abort |-> spi_rdata == '0);         // R6
    AST_AUX_LOSS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) aux_abort |-> aux_rdata == '0);         // R6
    AST_SPI_FLAG:     assert property (@(posedge clk) disable iff (!rst_n) spi_abort |-> col_flags[0]);              // R7
    AST_AUX_FLAG:     assert property (@(posedge clk) disable iff (!rst_n) aux_abort |-> col_flags[1]);              // R7

endmodule

bind dual_host_arb dual_host_arb_chk #(.DW(DW)) u_chk (.*);

// File: tb/dual_host_arb_bench.sv
module dual_host_arb_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_req = 0, spi_we = 0, aux_req = 0, aux_we = 0;
    logic [7:0] spi_addr = 0, spi_wdata = 0, aux_addr = 0, aux_wdata = 0;
    logic       spi_gnt, spi_abort, aux_gnt, aux_abort;
    logic [7:0] spi_rdata, aux_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dual_host_arb u_dual_host_arb (.*);

    // row: sreq swe saddr swdata areq awe aaddr awdata | egs eas ers ega eaa era
    typedef logic [55:0] vec_t;
    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        {1'b0,1'b0,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00, 1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00}, // 0  R9 idle
        {1'b1,1'b1,8'h01,8'h5A, 1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00}, // 1  R11 write
        {1'b1,1'b0,8'h01,8'h00, 1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h5A, 1'b0,1'b0,8'h00}, // 2  R3 readback
        {1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h01,8'h00, 1'b0,1'b0,8'h00, 1'b1,1'b0,8'h5A}, // 3  R2 lone aux
        {1'b1,1'b1,8'h02,8'h11, 1'b1,1'b0,8'h01,8'h00, 1'b0,1'b1,8'h00, 1'b1,1'b0,8'h5A}, // 4  R4 aux wins
        {1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h02,8'h00, 1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00}, // 5  R6 lost write
        {1'b1,1'b0,8'h4A,8'h00, 1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h01, 1'b0,1'b0,8'h00}, // 6  R7 spi flag
        {1'b1,1'b0,8'h4A,8'h00, 1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00}, // 7  R8 cleared
        {1'b0,1'b0,8'h00,8'h00, 1'b1,1'b1,8'h03,8'h02, 1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00}, // 8  R5 set prio
        {1'b1,1'b0,8'h01,8'h00, 1'b1,1'b1,8'h01,8'hFF, 1'b1,1'b0,8'h5A, 1'b0,1'b1,8'h00}, // 9  R5 spi wins
        {1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h01,8'h00, 1'b0,1'b0,8'h00, 1'b1,1'b0,8'h5A}, // 10 R6 unchanged
        {1'b1,1'b0,8'h4A,8'h00, 1'b1,1'b0,8'h01,8'h00, 1'b1,1'b0,8'h02, 1'b0,1'b1,8'h00}, // 11 R8 same-cycle
        {1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h4A,8'h00, 1'b0,1'b0,8'h00, 1'b1,1'b0,8'h02}, // 12 R8 kept
        {1'b1,1'b0,8'h4A,8'h00, 1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00}, // 13 R8 clear
        {1'b1,1'b1,8'h20,8'h77, 1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00}, // 14 R10 hole wr
        {1'b1,1'b0,8'h20,8'h00, 1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00}, // 15 R10 hole rd
        {1'b1,1'b1,8'h4A,8'hFF, 1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00}, // 16 R10 stat wr
        {1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h4A,8'h00, 1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00}, // 17 R10 stat rd
        {1'b1,1'b0,8'h03,8'h00, 1'b1,1'b0,8'h03,8'h00, 1'b1,1'b0,8'h02, 1'b0,1'b1,8'h00}, // 18 R6 loser read
        {1'b0,1'b0,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00, 1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00}  // 19 R9 quiet
    };

    function automatic string tag_of(input int i);
        case (i)
            1:            return "R11";
            2:            return "R3";
            3:            return "R2";
            4:            return "R4";
            5, 10, 18:    return "R6";
            6:            return "R7";
            7, 11, 12, 13: return "R8";
            8, 9:         return "R5";
            14, 15, 16, 17: return "R10";
            default:      return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // drive at falling edge, sample at the next falling edge, then release
    task automatic step(input vec_t v, input string tag);
        {spi_req, spi_we, spi_addr, spi_wdata, aux_req, aux_we, aux_addr, aux_wdata} = v[55:20];
        @(posedge clk);
        @(negedge clk);
        chk(tag, "spi_gnt",   {7'b0, spi_gnt},   {7'b0, v[19]});
        chk(tag, "spi_abort", {7'b0, spi_abort}, {7'b0, v[18]});
        chk(tag, "spi_rdata", spi_rdata,         v[17:10]);
        chk(tag, "aux_gnt",   {7'b0, aux_gnt},   {7'b0, v[9]});
        chk(tag, "aux_abort", {7'b0, aux_abort}, {7'b0, v[8]});
        chk(tag, "aux_rdata", aux_rdata,         v[7:0]);
        spi_req = 0; spi_we = 0; aux_req = 0; aux_we = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during and right after reset
        chk("R1", "gnt/abort in reset", {4'b0, spi_gnt, spi_abort, aux_gnt, aux_abort}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "spi_rdata after reset", spi_rdata, 8'h00);
        chk("R1", "aux_rdata after reset", aux_rdata, 8'h00);

        for (int i = 0; i < NV; i++) step(TBL[i], tag_of(i));

        // R1: reset mid-run clears storage and flags
        step({1'b1,1'b1,8'h04,8'hC3, 1'b1,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b1,8'h00}, "R5");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        step({1'b1,1'b0,8'h04,8'h00, 1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00}, "R1");
        step({1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h4A,8'h00, 1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00}, "R1");
        // R4: priority back to default after reset
        step({1'b1,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h00,8'h00, 1'b0,1'b1,8'h00, 1'b1,1'b0,8'h00}, "R4");
        // R2: lone spi request with SPI priority clear, back to back
        step({1'b1,1'b1,8'h07,8'hA5, 1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00}, "R2");
        step({1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,8'h07,8'h00, 1'b0,1'b0,8'h00, 1'b1,1'b0,8'hA5}, "R3");
        finish_run();
    end

endmodule